// File: doc/BRIEF.md
# Battery Charge Sequencer

This block is the top-level phase sequencer of a nickel-chemistry battery charger. Analog comparators and sample filters elsewhere in the chip reduce the cell voltage and the thermistor voltage to single-bit flags. The flags say whether the cell is below the end-of-discharge level or above the maximum level, and whether the temperature is too cold, too hot or past the hard cutoff. Slope detectors add a rate-of-temperature flag and a voltage-drop flag. The sequencer combines these flags with three asynchronous command lines: a discharge command (active low), a charge inhibit (active low) and a power-good signal. From them it decides which charge phase the battery is in.

The phases are idle, discharge, pending, fast charge, top-off, pulse-trickle, maximum-voltage hold, complete and battery-absent. The current is modulated downstream and the status lights are driven there too, both keyed off a registered 4-bit phase code. The sequencer itself drives only the discharge switch. Fast charge and top-off are each bounded by a safety timer, whose length is chosen by a 3-bit timer select. A second timer separates a battery that has been pulled out from one that is simply full: a cell that stays above the maximum level for the whole hold window is taken as removed.

Top module: `chg_seq_top`

## Requirements
- R1: After reset, and whenever the synchronised inhibit is low or power-good is low, the phase code is 0 (idle) and the discharge output is low. Discharge commands are ignored while idle.
- R2: A new cycle starts on a rising inhibit while power is good, or on rising power-good while inhibit is high. It enters pending (code 2) when the discharge command is high, or discharge (code 1) when it is held low. The asynchronous commands act 3 clock edges after they change.
- R3: A falling edge on the discharge command moves any non-idle phase to discharge (code 1). The discharge output is high only in that phase.
- R4: Discharge ends when the below-end-of-discharge flag is set, and the sequencer then enters pending.
- R5: Pending moves to fast charge (code 3) only when the cell is neither below end-of-discharge nor above maximum, and the temperature is neither too hot nor too cold. Otherwise it waits with no time limit. An above-maximum cell in pending leads to battery-absent (code 8).
- R6: When peak-detect mode is selected, the too-cold flag is ignored both for qualification and for ending fast charge.
- R7: Fast charge ends on the cutoff, rate-of-temperature or voltage-drop flag, or on too-cold outside peak-detect mode. It then goes to top-off (code 4) if top-off is enabled, else to pulse-trickle (code 5).
- R8: The safety timer ends fast charge after SAFE_UNIT << (4 - s) ticks for select value s from 0 to 4. Select values 5 to 7 act as 4.
- R9: Top-off restarts the safety timer from zero. It ends only on cutoff or timer expiry, both of which lead to pulse-trickle. The rate-of-temperature and voltage-drop flags have no effect in top-off.
- R10: An above-maximum cell in fast charge, top-off, pulse-trickle or complete enters maximum-voltage hold (code 6) on the next edge, and charging stops.
- R11: In hold, a cell that falls below maximum before MCV_TICKS ticks leads to complete (code 7). A cell that is still above maximum when the window expires leads to battery-absent (code 8).
- R12: In battery-absent, a cell falling below maximum (a new battery) starts a new cycle as in R2.
- R13: Pulse-trickle and complete have no time limit.
- R14: Exactly one state bit is set at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good_i | input | 1 | Supply valid, asynchronous |
| inh_n_i | input | 1 | Charge inhibit, active low, asynchronous |
| dcmd_n_i | input | 1 | Discharge command, active low, asynchronous |
| pvd_mode_i | input | 1 | Peak-detect mode selected |
| topoff_en_i | input | 1 | Top-off phase enabled |
| tsel_i | input | 3 | Safety time select |
| cell_lo_i | input | 1 | Cell below end-of-discharge level |
| cell_hi_i | input | 1 | Cell above maximum level |
| temp_cold_i | input | 1 | Temperature beyond low-fault level |
| temp_hot_i | input | 1 | Temperature beyond high-fault level |
| temp_cut_i | input | 1 | Temperature beyond cutoff level |
| dtdt_i | input | 1 | Rate-of-temperature termination flag |
| vdrop_i | input | 1 | Voltage-drop termination flag |
| dis_o | output | 1 | Discharge switch drive |
| phase_o | output | 4 | Registered phase code |

## Verification
A synchronous flag changes the phase code at the very next clock edge. The bench drives each flag one time unit after an edge and samples one edge later. A change on the three command lines reaches the phase code at the third edge, so the bench samples one edge early to see the old phase and again at the third edge to see the new one. The safety timer and the hold window run on a free prescaler tick whose phase the bench does not track. Each of them is therefore checked at two points: one tick before the earliest possible expiry, where the old phase must still hold, and just past the latest possible expiry, where the new phase must be present.

// File: rtl/chg_pkg.sv
package chg_pkg;

  localparam int NST = 9;

  localparam int S_IDLE    = 0;
  localparam int S_DISCH   = 1;
  localparam int S_PEND    = 2;
  localparam int S_FAST    = 3;
  localparam int S_TOPOFF  = 4;
  localparam int S_TRICKLE = 5;
  localparam int S_HOLD    = 6;
  localparam int S_DONE    = 7;
  localparam int S_ABSENT  = 8;

  localparam int PHW = 4;

  typedef logic [NST-1:0] st_vec_t;

  function automatic st_vec_t st_one(input int idx);
    st_vec_t v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction

  // phase code equals the index of the active state bit
  function automatic logic [PHW-1:0] st_code(input st_vec_t s);
    logic [PHW-1:0] c;
    c = '0;
    for (int i = 0; i < NST; i++) begin
      if (s[i]) c = PHW'(i);
    end
    return c;
  endfunction

endpackage

// File: rtl/chg_sync.sv
module chg_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] lvl_d
);

  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
      prev_q <= RST_VAL;
    end else begin
      stg_q[0] <= din;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      prev_q <= stg_q[STAGES-1];
    end
  end

  assign lvl   = stg_q[STAGES-1];
  assign lvl_d = prev_q;

endmodule

// File: rtl/chg_tmr.sv
module chg_tmr #(
  parameter int CLK_PER_TICK = 100000,
  parameter int SAFE_UNIT    = 1350000,
  parameter int MCV_TICKS    = 1500
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] tsel,
  input  logic       safe_run,
  input  logic       safe_clr,
  input  logic       mcv_run,
  output logic       safe_exp,
  output logic       mcv_exp
);

  localparam int SAFE_MAX = SAFE_UNIT * 16;
  localparam int SW = $clog2(SAFE_MAX + 1);
  localparam int MW = $clog2(MCV_TICKS + 1);

  logic tick;

  generate
    if (CLK_PER_TICK <= 1) begin : g_nodiv
      assign tick = 1'b1;
    end else begin : g_div
      localparam int PW = $clog2(CLK_PER_TICK);
      logic [PW-1:0] pc_q;
      always_ff @(posedge clk) begin
        if (rst || pc_q == PW'(CLK_PER_TICK - 1)) pc_q <= '0;
        else pc_q <= pc_q + 1'b1;
      end
      assign tick = (pc_q == PW'(CLK_PER_TICK - 1));
    end
  endgenerate

  logic [2:0]    sh;
  logic [SW-1:0] lim;
  logic [SW-1:0] safe_q;
  logic [MW-1:0] mcv_q;

  always_comb begin
    sh  = (tsel > 3'd4) ? 3'd0 : 3'd4 - tsel;
    lim = SW'(SAFE_UNIT) << sh;
  end

  assign safe_exp = (safe_q >= lim);
  assign mcv_exp  = (mcv_q >= MW'(MCV_TICKS));

  always_ff @(posedge clk) begin
    if (rst || safe_clr) safe_q <= '0;
    else if (safe_run && tick && !safe_exp) safe_q <= safe_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !mcv_run) mcv_q <= '0;
    else if (tick && !mcv_exp) mcv_q <= mcv_q + 1'b1;
  end

  // R11: the hold window restarts whenever the hold phase is left
  assert_mcv_clear_R11: assert property (@(posedge clk) disable iff (rst)
    !mcv_run |=> !mcv_exp);

  // R8: once expired the safety timer stays expired until cleared
  assert_safe_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (safe_run && safe_exp && !safe_clr) |=> (safe_exp || !$stable(tsel)));

endmodule

// File: rtl/chg_fsm.sv
module chg_fsm
  import chg_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           run_ok,
  input  logic           start,
  input  logic           dcmd_lvl,
  input  logic           dcmd_fall,
  input  logic           pvd_mode,
  input  logic           topoff_en,
  input  logic           cell_lo,
  input  logic           cell_hi,
  input  logic           temp_cold,
  input  logic           temp_hot,
  input  logic           temp_cut,
  input  logic           dtdt,
  input  logic           vdrop,
  input  logic           safe_exp,
  input  logic           mcv_exp,
  output logic           safe_run,
  output logic           safe_clr,
  output logic           mcv_run,
  output logic           dis_o,
  output logic [PHW-1:0] phase_o
);

  st_vec_t state_q, state_d, first_st;
  logic    cold_fault, qual, fast_end, top_end;

  always_comb begin
    cold_fault = temp_cold & ~pvd_mode;
    qual       = ~cell_lo & ~cell_hi & ~temp_hot & ~cold_fault;
    fast_end   = temp_cut | dtdt | vdrop | cold_fault | safe_exp;
    top_end    = temp_cut | safe_exp;
    first_st   = dcmd_lvl ? st_one(S_PEND) : st_one(S_DISCH);
  end

  always_comb begin
    state_d = state_q;
    if (!run_ok) begin
      state_d = st_one(S_IDLE);
    end else if (start) begin
      state_d = first_st;
    end else if (dcmd_fall && !state_q[S_IDLE]) begin
      state_d = st_one(S_DISCH);
    end else if (state_q[S_DISCH]) begin
      if (cell_lo) state_d = st_one(S_PEND);
    end else if (state_q[S_PEND]) begin
      if (cell_hi) state_d = st_one(S_ABSENT);
      else if (qual) state_d = st_one(S_FAST);
    end else if (state_q[S_FAST]) begin
      if (cell_hi) state_d = st_one(S_HOLD);
      else if (fast_end) state_d = topoff_en ? st_one(S_TOPOFF) : st_one(S_TRICKLE);
    end else if (state_q[S_TOPOFF]) begin
      if (cell_hi) state_d = st_one(S_HOLD);
      else if (top_end) state_d = st_one(S_TRICKLE);
    end else if (state_q[S_TRICKLE] || state_q[S_DONE]) begin
      if (cell_hi) state_d = st_one(S_HOLD);
    end else if (state_q[S_HOLD]) begin
      if (!cell_hi) state_d = st_one(S_DONE);
      else if (mcv_exp) state_d = st_one(S_ABSENT);
    end else if (state_q[S_ABSENT]) begin
      if (!cell_hi) state_d = first_st;
    end
  end

  assign safe_run = state_q[S_FAST] | state_q[S_TOPOFF];
  assign safe_clr = ~safe_run | (state_q[S_FAST] & state_d[S_TOPOFF]);
  assign mcv_run  = state_q[S_HOLD];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= st_one(S_IDLE);
      phase_o <= '0;
      dis_o   <= 1'b0;
    end else begin
      state_q <= state_d;
      phase_o <= st_code(state_d);
      dis_o   <= state_d[S_DISCH];
    end
  end

  assert_onehot_R14: assert property (@(posedge clk) disable iff (rst)
    $countones(state_q) == 1);

  assert_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !run_ok |=> state_q[S_IDLE]);

  assert_pend_qual_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q[S_FAST] && $past(state_q[S_PEND])) |-> $past(qual));

  assert_hold_entry_R10: assert property (@(posedge clk) disable iff (rst)
    (run_ok && !start && !dcmd_fall && state_q[S_FAST] && cell_hi) |=> state_q[S_HOLD]);

  assert_absent_R11: assert property (@(posedge clk) disable iff (rst)
    (state_q[S_ABSENT] && $past(state_q[S_HOLD])) |-> $past(mcv_exp));

endmodule

// File: rtl/chg_seq_top.sv
module chg_seq_top
  import chg_pkg::*;
#(
  parameter int CLK_PER_TICK = 100000,
  parameter int SAFE_UNIT    = 1350000,
  parameter int MCV_TICKS    = 1500,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pwr_good_i,
  input  logic       inh_n_i,
  input  logic       dcmd_n_i,
  input  logic       pvd_mode_i,
  input  logic       topoff_en_i,
  input  logic [2:0] tsel_i,
  input  logic       cell_lo_i,
  input  logic       cell_hi_i,
  input  logic       temp_cold_i,
  input  logic       temp_hot_i,
  input  logic       temp_cut_i,
  input  logic       dtdt_i,
  input  logic       vdrop_i,
  output logic       dis_o,
  output logic [3:0] phase_o
);

  // bit 0 power-good, bit 1 inhibit (active low), bit 2 discharge command (active low)
  logic [2:0] cmd_lvl, cmd_lvl_d;
  logic       run_ok, start, dcmd_fall;
  logic       safe_run, safe_clr, mcv_run, safe_exp, mcv_exp;

  chg_sync #(
    .W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)
  ) u_sync (
    .clk(clk), .rst(rst),
    .din({dcmd_n_i, inh_n_i, pwr_good_i}),
    .lvl(cmd_lvl), .lvl_d(cmd_lvl_d)
  );

  assign run_ok    = cmd_lvl[0] & cmd_lvl[1];
  assign start     = run_ok & ((cmd_lvl[0] & ~cmd_lvl_d[0]) | (cmd_lvl[1] & ~cmd_lvl_d[1]));
  assign dcmd_fall = ~cmd_lvl[2] & cmd_lvl_d[2];

  chg_tmr #(
    .CLK_PER_TICK(CLK_PER_TICK), .SAFE_UNIT(SAFE_UNIT), .MCV_TICKS(MCV_TICKS)
  ) u_tmr (
    .clk(clk), .rst(rst), .tsel(tsel_i),
    .safe_run(safe_run), .safe_clr(safe_clr), .mcv_run(mcv_run),
    .safe_exp(safe_exp), .mcv_exp(mcv_exp)
  );

  chg_fsm u_fsm (
    .clk(clk), .rst(rst), .run_ok(run_ok), .start(start),
    .dcmd_lvl(cmd_lvl[2]), .dcmd_fall(dcmd_fall),
    .pvd_mode(pvd_mode_i), .topoff_en(topoff_en_i),
    .cell_lo(cell_lo_i), .cell_hi(cell_hi_i),
    .temp_cold(temp_cold_i), .temp_hot(temp_hot_i), .temp_cut(temp_cut_i),
    .dtdt(dtdt_i), .vdrop(vdrop_i),
    .safe_exp(safe_exp), .mcv_exp(mcv_exp),
    .safe_run(safe_run), .safe_clr(safe_clr), .mcv_run(mcv_run),
    .dis_o(dis_o), .phase_o(phase_o)
  );

  assert_dis_phase_R3: assert property (@(posedge clk) disable iff (rst)
    dis_o |-> (phase_o == 4'd1));

endmodule

// File: tb/chg_seq_top_tb.sv
module chg_seq_top_tb;

  localparam int P  = 4;
  localparam int SU = 8;
  localparam int MT = 10;

  localparam logic [3:0] IDLE = 4'd0, DISCH = 4'd1, PEND = 4'd2, FAST = 4'd3,
                         TOPOFF = 4'd4, TRICKLE = 4'd5, HOLD = 4'd6, DONE = 4'd7,
                         ABSENT = 4'd8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic pwr_good = 1'b1, inh_n = 1'b1, dcmd_n = 1'b1, pvd_mode = 1'b0, topoff_en = 1'b0;
  logic [2:0] tsel = 3'd0;
  logic cell_lo = 1'b1, cell_hi = 1'b0, temp_cold = 1'b0, temp_hot = 1'b0, temp_cut = 1'b0;
  logic dtdt = 1'b0, vdrop = 1'b0;
  logic dis;
  logic [3:0] phase;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  chg_seq_top #(.CLK_PER_TICK(P), .SAFE_UNIT(SU), .MCV_TICKS(MT)) u_dut (
    .clk(clk), .rst(rst), .pwr_good_i(pwr_good), .inh_n_i(inh_n), .dcmd_n_i(dcmd_n),
    .pvd_mode_i(pvd_mode), .topoff_en_i(topoff_en), .tsel_i(tsel),
    .cell_lo_i(cell_lo), .cell_hi_i(cell_hi), .temp_cold_i(temp_cold),
    .temp_hot_i(temp_hot), .temp_cut_i(temp_cut), .dtdt_i(dtdt), .vdrop_i(vdrop),
    .dis_o(dis), .phase_o(phase)
  );

  task automatic adv(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [3:0] got, input logic [3:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  function automatic logic [3:0] exp_pend(input logic hi, lo, cold, hot, pvd);
    if (hi) return ABSENT;
    if (!lo && !hot && !(cold && !pvd)) return FAST;
    return PEND;
  endfunction

  function automatic logic [3:0] exp_fast(input logic hi, cut, dt, vd, cold, pvd, top);
    if (hi) return HOLD;
    if (cut || dt || vd || (cold && !pvd)) return top ? TOPOFF : TRICKLE;
    return FAST;
  endfunction

  task automatic restart();
    cell_lo = 1'b1; cell_hi = 1'b0; temp_cold = 1'b0; temp_hot = 1'b0;
    temp_cut = 1'b0; dtdt = 1'b0; vdrop = 1'b0; dcmd_n = 1'b1;
    inh_n = 1'b0;
    adv(4);
    inh_n = 1'b1;
    adv(4);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(150000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'h5eed_c4a6));
    adv(3);
    rst = 1'b0;
    adv(1);
    chk("R1 reset phase", phase, IDLE);
    chk("R1 reset dis", {3'b0, dis}, 4'd0);
    adv(1);
    chk("R2 start not before third edge", phase, IDLE);
    adv(1);
    chk("R2 start into pending", phase, PEND);

    adv(300);
    chk("R5 pending without time limit", phase, PEND);
    cell_lo = 1'b0;
    adv(1);
    chk("R5 qualified to fast", phase, FAST);

    topoff_en = 1'b0; vdrop = 1'b1;
    adv(1);
    chk("R7 voltage drop to trickle", phase, TRICKLE);
    vdrop = 1'b0;
    adv(600);
    chk("R13 trickle without time limit", phase, TRICKLE);

    cell_hi = 1'b1;
    adv(1);
    chk("R10 over-voltage hold", phase, HOLD);
    adv(3);
    cell_hi = 1'b0;
    adv(1);
    chk("R11 quick return to complete", phase, DONE);
    adv(200);
    chk("R13 complete without time limit", phase, DONE);

    cell_hi = 1'b1;
    adv(1);
    chk("R10 hold from complete", phase, HOLD);
    adv((MT - 1) * P - 1);
    chk("R11 hold before window end", phase, HOLD);
    adv(7);
    chk("R11 window expiry to absent", phase, ABSENT);

    cell_hi = 1'b0;
    adv(1);
    chk("R12 battery inserted restarts", phase, PEND);
    topoff_en = 1'b1; tsel = 3'd0;
    adv(1);
    chk("R5 restart qualifies", phase, FAST);
    adv(16 * SU * P - P + 1 - 1);
    chk("R8 safety time not yet", phase, FAST);
    adv(5);
    chk("R8 safety expiry to topoff", phase, TOPOFF);
    dtdt = 1'b1; vdrop = 1'b1;
    adv(1);
    chk("R9 slope flags ignored in topoff", phase, TOPOFF);
    dtdt = 1'b0; vdrop = 1'b0;
    adv(479);
    chk("R9 topoff timer restarted", phase, TOPOFF);
    adv(36);
    chk("R9 topoff expiry to trickle", phase, TRICKLE);

    tsel = 3'd6; topoff_en = 1'b0;
    restart();
    chk("R2 restart via inhibit", phase, PEND);
    cell_lo = 1'b0;
    adv(1);
    chk("R5 fast for short timer", phase, FAST);
    adv(SU * P - P + 1);
    chk("R8 select 6 acts as 4, not yet", phase, FAST);
    adv(5);
    chk("R8 select 6 acts as 4, expired", phase, TRICKLE);

    dcmd_n = 1'b0;
    adv(2);
    chk("R3 command not before third edge", phase, TRICKLE);
    dcmd_n = 1'b1;
    adv(1);
    chk("R3 command pulse to discharge", phase, DISCH);
    chk("R3 discharge output high", {3'b0, dis}, 4'd1);
    adv(50);
    chk("R4 discharge holds until empty", phase, DISCH);
    cell_lo = 1'b1;
    adv(1);
    chk("R4 empty to pending", phase, PEND);
    chk("R3 discharge output low", {3'b0, dis}, 4'd0);

    dcmd_n = 1'b0; cell_lo = 1'b0; inh_n = 1'b0;
    adv(4);
    chk("R1 inhibit to idle", phase, IDLE);
    inh_n = 1'b1;
    adv(3);
    chk("R2 tied-low command starts with discharge", phase, DISCH);
    cell_lo = 1'b1;
    adv(1);
    chk("R4 discharge end to pending", phase, PEND);
    dcmd_n = 1'b1;
    adv(3);

    inh_n = 1'b0;
    adv(4);
    dcmd_n = 1'b0;
    adv(2);
    dcmd_n = 1'b1;
    adv(4);
    chk("R1 command ignored while idle", phase, IDLE);
    chk("R1 no discharge while idle", {3'b0, dis}, 4'd0);
    inh_n = 1'b1; pwr_good = 1'b0;
    adv(4);
    chk("R1 no power stays idle", phase, IDLE);
    pwr_good = 1'b1;
    adv(3);
    chk("R2 power rise starts cycle", phase, PEND);

    for (int t = 0; t < 40; t++) begin
      restart();
      r = $urandom;
      cell_hi = (r[2:0] == 3'd0); cell_lo = r[3]; temp_cold = r[4];
      temp_hot = r[5]; pvd_mode = r[6];
      adv(1);
      chk("R5/R6 random qualification", phase,
          exp_pend(cell_hi, cell_lo, temp_cold, temp_hot, pvd_mode));
    end

    for (int t = 0; t < 40; t++) begin
      restart();
      r = $urandom;
      pvd_mode = r[6]; topoff_en = r[7]; tsel = 3'd0; cell_lo = 1'b0;
      adv(1);
      chk("R5 random trial entry", phase, FAST);
      temp_cut = r[8] & r[9]; dtdt = r[10] & r[11]; vdrop = r[12] & r[13];
      temp_cold = r[14]; cell_hi = (r[17:15] == 3'd0);
      adv(1);
      chk("R7/R6/R10 random fast termination", phase,
          exp_fast(cell_hi, temp_cut, dtdt, vdrop, temp_cold, pvd_mode, topoff_en));
    end

    done = 1'b1;
    finish_run();
  end

endmodule